// File: doc/BRIEF.md
# Two-Channel DMA Bus Arbiter

This block hands the system bus to one of three owners (the CPU, DMA channel 0 or DMA channel 1) one transfer unit at a time. Each channel carries a static configuration: bus mode (burst or cycle-steal), transfer unit size, request sensing (level or edge) and request polarity. The block senses the external request lines, rejects configurations that cannot work, and drives a one-hot grant. The bus side answers each granted unit with a single-cycle done pulse. Address generation, transfer counting and data movement belong to other blocks.

Channel 0 always outranks channel 1. A burst-mode channel keeps the CPU off the bus until it finishes its whole transfer. A cycle-steal channel gives the bus back after every unit. When channel 0 steals cycles while channel 1 is bursting, the two channels alternate unit by unit and the CPU gets no slot in between. A channel finishes either by removing its request (level sensing) or by an end pulse (edge sensing).

Top module: `dma_bus_arb`

## Requirements
- R1: After reset the CPU owns the bus (`gnt_o`=3'b001, `owner_o`=0) and `err_o`=0.
- R2: `gnt_o` is always one-hot. Bit 0 is the CPU, bit 1 is channel 0, bit 2 is channel 1. `owner_o` encodes the owner as 0=CPU, 1=channel 0, 2=channel 1.
- R3: A channel that is enabled with level sensing (`level_i`=1) and either burst mode (`burst_i`=1) or the 16-byte unit (`unit_i` code 3; codes 0/1/2 are byte/word/longword) raises its `err_o` bit on the first clock after reset and is never granted. Edge sensing is legal with every bus mode and every unit size. Polarity has no effect on legality.
- R4: In edge sensing, an active edge (rising when `pol_i`=1, falling when `pol_i`=0) is held as pending. In cycle-steal mode the pending request is used up when its unit is granted. In burst mode it stays pending until the end pulse.
- R5: In level sensing, the request is active while the line sits at its active level (high when `pol_i`=1). It is sampled again at each decision point, and one unit is granted per decision.
- R6: While a channel owns the bus, the grant changes only on a `unit_done_i` pulse. While the CPU owns the bus, a decision is made on every clock.
- R7: When channel 1 is bursting and channel 0 requests, channel 0 takes the bus at the next unit boundary.
- R8: When channel 0 is in burst mode, channel 1 gets the bus back only after channel 0 has ended its transfer.
- R9: When channel 0 is in cycle-steal mode and channel 1 is in burst mode, and both are requesting, the grants alternate one unit each with no CPU slot in between.
- R10: A cycle-steal channel never receives two units back to back. With no other channel waiting, the CPU holds the bus for exactly one cycle between its units.
- R11: An `end_i` pulse clears a burst channel's pending request. The bus then leaves that channel at its next unit boundary.
- R12: A channel whose `en_i` bit is 0 is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 2 | Channel enable, bit k = channel k |
| burst_i | input | 2 | 1 = burst mode, 0 = cycle-steal mode |
| level_i | input | 2 | 1 = level sensing, 0 = edge sensing |
| pol_i | input | 2 | 1 = high level / rising edge, 0 = low level / falling edge |
| unit_i | input | 4 | Unit size per channel, bits [2k+1:2k]: 0 byte, 1 word, 2 longword, 3 16-byte |
| dreq_i | input | 2 | External request lines |
| end_i | input | 2 | End-of-transfer pulse per channel |
| unit_done_i | input | 1 | One-cycle pulse that closes the granted unit |
| gnt_o | output | 3 | One-hot grant {ch1, ch0, cpu} |
| owner_o | output | 2 | Current owner code |
| err_o | output | 2 | Sticky illegal-configuration flag per channel |

## Verification
The arbitration is exercised with each pairing of bus modes: both channels in burst mode, a cycle-steal channel 0 against a bursting channel 1, and each channel alone. These runs separate preemption at a boundary, wait-until-finished and unit-by-unit alternation. Edge and level sensing are tried with both polarities, which shows the difference between a latched request and one sampled afresh at each boundary. Randomised configurations, including illegal ones, run with random request toggles, end pulses and done timing. They check the one-hot grant, the hold between done pulses, the blocking of illegal or disabled channels and the gap after every cycle-steal unit.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int NCH    = 2;
  localparam int UNIT_W = 2;
  localparam int OWN_W  = 2;

  typedef enum logic [OWN_W-1:0] {
    OWN_CPU = 2'd0,
    OWN_CH0 = 2'd1,
    OWN_CH1 = 2'd2
  } owner_e;

  typedef enum logic [UNIT_W-1:0] {
    U_BYTE = 2'd0,
    U_WORD = 2'd1,
    U_LONG = 2'd2,
    U_16B  = 2'd3
  } unit_e;

  // level sensing allows only cycle-steal and units up to longword
  function automatic logic cfg_legal(logic level, logic burst, logic [UNIT_W-1:0] unit);
    return !level || (!burst && unit != U_16B);
  endfunction
endpackage

// File: rtl/dma_req_sense.sv
module dma_req_sense
  import dma_arb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              level_i,
  input  logic              pol_i,
  input  logic              burst_i,
  input  logic [UNIT_W-1:0] unit_i,
  input  logic              dreq_i,
  input  logic              end_i,
  input  logic              take_i,
  output logic              want_o,
  output logic              err_o
);
  logic smp_q, prev_q, pend_q, err_q;
  logic act, bad, edge_hit, pend_d;

  assign act      = en_i & (dreq_i ~^ pol_i);
  assign bad      = en_i & ~cfg_legal(level_i, burst_i, unit_i);
  assign edge_hit = smp_q & ~prev_q;

  always_comb begin
    pend_d = (pend_q & ~end_i & ~(take_i & ~burst_i)) | edge_hit;
    if (!en_i || level_i) pend_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q  <= 1'b0;
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      smp_q  <= act;
      prev_q <= smp_q;
      pend_q <= pend_d;
      err_q  <= err_q | bad;
    end
  end

  assign want_o = en_i & ~bad & ~err_q & (level_i ? smp_q : pend_q);
  assign err_o  = err_q;
endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick
  import dma_arb_pkg::*;
(
  input  owner_e         owner_i,
  input  logic           done_i,
  input  logic [NCH-1:0] want_i,
  input  logic [NCH-1:0] burst_i,
  output logic           dec_o,
  output owner_e         nxt_o
);
  owner_e prev;

  assign dec_o = (owner_i == OWN_CPU) || done_i;
  assign prev  = done_i ? owner_i : OWN_CPU;

  always_comb begin
    nxt_o = OWN_CPU;
    if (want_i[0] && want_i[1]) begin
      if (burst_i[0])            nxt_o = OWN_CH0;
      else if (prev == OWN_CH0)  nxt_o = OWN_CH1;
      else                       nxt_o = OWN_CH0;
    end else if (want_i[0]) begin
      nxt_o = (!burst_i[0] && prev == OWN_CH0) ? OWN_CPU : OWN_CH0;
    end else if (want_i[1]) begin
      nxt_o = (!burst_i[1] && prev == OWN_CH1) ? OWN_CPU : OWN_CH1;
    end
  end
endmodule

// File: rtl/dma_bus_arb.sv
module dma_bus_arb
  import dma_arb_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NCH-1:0]        en_i,
  input  logic [NCH-1:0]        burst_i,
  input  logic [NCH-1:0]        level_i,
  input  logic [NCH-1:0]        pol_i,
  input  logic [NCH*UNIT_W-1:0] unit_i,
  input  logic [NCH-1:0]        dreq_i,
  input  logic [NCH-1:0]        end_i,
  input  logic                  unit_done_i,
  output logic [NCH:0]          gnt_o,
  output logic [OWN_W-1:0]      owner_o,
  output logic [NCH-1:0]        err_o
);
  owner_e         owner_q, nxt;
  logic           dec;
  logic [NCH-1:0] want, take;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign take[k] = dec && (nxt == owner_e'(k + 1));
    dma_req_sense u_sense (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_i[k]),
      .level_i (level_i[k]),
      .pol_i   (pol_i[k]),
      .burst_i (burst_i[k]),
      .unit_i  (unit_i[k*UNIT_W +: UNIT_W]),
      .dreq_i  (dreq_i[k]),
      .end_i   (end_i[k]),
      .take_i  (take[k]),
      .want_o  (want[k]),
      .err_o   (err_o[k])
    );
  end

  dma_arb_pick u_pick (
    .owner_i (owner_q),
    .done_i  (unit_done_i),
    .want_i  (want),
    .burst_i (burst_i),
    .dec_o   (dec),
    .nxt_o   (nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  owner_q <= OWN_CPU;
    else if (dec) owner_q <= nxt;
  end

  always_comb begin
    gnt_o = '0;
    gnt_o[owner_q] = 1'b1;
  end
  assign owner_o = owner_q;
endmodule

// File: rtl/dma_bus_arb_chk.sv
module dma_bus_arb_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       unit_done_i,
  input logic [1:0] burst_i,
  input logic [2:0] gnt_o,
  input logic [1:0] err_o
);
  // R2
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gnt_o) == 1);

  // R6
  gnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gnt_o[0] && !unit_done_i) |=> $stable(gnt_o));

  // R3
  err0_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o[0] && (unit_done_i || gnt_o[0])) |=> !gnt_o[1]);

  // R3
  err1_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o[1] && (unit_done_i || gnt_o[0])) |=> !gnt_o[2]);

  // R10
  cs_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o[1] && unit_done_i && !burst_i[0]) |=> !gnt_o[1]);
endmodule

bind dma_bus_arb dma_bus_arb_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .unit_done_i (unit_done_i),
  .burst_i     (burst_i),
  .gnt_o       (gnt_o),
  .err_o       (err_o)
);

// File: tb/dma_bus_arb_tb.sv
module dma_bus_arb_tb;
  logic       clk = 0, rst_n = 0;
  logic [1:0] en = 0, burst = 0, level = 0, pol = 0, dreq = 0, endp = 0;
  logic [3:0] unit = 0;
  logic       done = 0;
  logic [2:0] gnt;
  logic [1:0] owner, err;
  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  dma_bus_arb u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .burst_i(burst), .level_i(level),
    .pol_i(pol), .unit_i(unit), .dreq_i(dreq), .end_i(endp), .unit_done_i(done),
    .gnt_o(gnt), .owner_o(owner), .err_o(err));

  localparam logic [2:0] G_CPU = 3'b001, G_C0 = 3'b010, G_C1 = 3'b100;

  function automatic bit legal_f(bit lv, bit bu, bit [1:0] un);
    return !(lv && (bu || un == 2'd3));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; done = 0; endp = 0;
    tick(2);
    rst_n = 1;
    tick(1);
  endtask

  task automatic pulse_done();
    done = 1; tick(1); done = 0;
  endtask

  task automatic pulse_end(input int k);
    endp[k] = 1; tick(1); endp = 0;
  endtask

  initial begin
    #800000;
    n_err++; n_chk++;
    $display("FAIL watchdog act=0 exp=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    bit [2:0] g_prev;
    bit d_prev;
    // R1 reset state
    en = 2'b11; pol = 2'b11; unit = 4'b0101;
    do_reset();
    eq("R1 gnt", gnt, G_CPU);
    eq("R1 owner", owner, 0);
    eq("R1 err", err, 0);

    // R4 rising edge, cycle-steal ch0
    dreq[0] = 1; tick(4);
    eq("R4 edge grant", gnt, G_C0);
    eq("R2 owner code", owner, 1);
    pulse_done();
    eq("R4 consumed", gnt, G_CPU);
    tick(3);
    eq("R4 no re-grant", gnt, G_CPU);
    dreq[0] = 0; tick(2); dreq[0] = 1; tick(4);
    eq("R4 second edge", gnt, G_C0);
    pulse_done(); dreq[0] = 0;

    // R4 falling edge
    pol = 2'b10; dreq = 2'b01; do_reset();
    tick(3);
    eq("R4 idle high", gnt, G_CPU);
    dreq[0] = 0; tick(4);
    eq("R4 falling grant", gnt, G_C0);
    pulse_done();

    // R5 level high, R10 one-cycle CPU gap
    pol = 2'b11; level = 2'b01; dreq = 0; do_reset();
    dreq[0] = 1; tick(3);
    eq("R5 level grant", gnt, G_C0);
    pulse_done();
    eq("R10 cpu gap", gnt, G_CPU);
    tick(1);
    eq("R10 gap one cycle", gnt, G_C0);
    dreq[0] = 0; tick(2); pulse_done();
    eq("R5 level drop", gnt, G_CPU);

    // R3 illegal configs
    level = 2'b11; burst = 2'b01; unit = 4'b1100; dreq = 0; do_reset();
    tick(1);
    eq("R3 err both", err, 2'b11);
    dreq = 2'b11; tick(6);
    eq("R3 no grant", gnt, G_CPU);
    dreq = 0;

    // R3 edge + 16B + burst legal
    level = 0; burst = 2'b01; unit = 4'b0011; do_reset();
    tick(1);
    eq("R3 edge legal", err, 0);
    dreq[0] = 1; tick(4);
    eq("R3 16B grant", gnt, G_C0);
    pulse_end(0); pulse_done(); dreq = 0;

    // R12 disabled
    en = 2'b10; burst = 0; unit = 0; do_reset();
    dreq[0] = 1; tick(5);
    eq("R12 disabled", gnt, G_CPU);
    dreq = 0; en = 2'b11;

    // R7 R9 R11: ch0 level cycle-steal, ch1 edge burst
    level = 2'b01; burst = 2'b10; unit = 4'b1001; do_reset();
    dreq[1] = 1; tick(4);
    eq("R4 burst grant", gnt, G_C1);
    pulse_done();
    eq("R4 burst holds", gnt, G_C1);
    dreq[0] = 1; tick(4);
    eq("R6 held no done", gnt, G_C1);
    pulse_done();
    eq("R7 preempt", gnt, G_C0);
    pulse_done();
    eq("R9 alt ch1", gnt, G_C1);
    pulse_done();
    eq("R9 alt ch0", gnt, G_C0);
    pulse_done();
    eq("R9 alt ch1 again", gnt, G_C1);
    pulse_end(1);
    pulse_done();
    eq("R11 to ch0", gnt, G_C0);
    pulse_done();
    eq("R11 burst gone", gnt, G_CPU);
    tick(1);
    eq("R10 back ch0", gnt, G_C0);
    dreq = 0; tick(2); pulse_done();

    // R8 both edge burst
    level = 0; burst = 2'b11; do_reset();
    dreq[1] = 1; tick(4);
    eq("R8 ch1 start", gnt, G_C1);
    dreq[0] = 1; tick(4);
    eq("R6 ch1 held", gnt, G_C1);
    pulse_done();
    eq("R7 burst preempt", gnt, G_C0);
    for (int i = 0; i < 3; i++) begin
      pulse_done();
      eq("R8 ch0 keeps", gnt, G_C0);
    end
    pulse_end(0); pulse_done();
    eq("R8 ch1 resumes", gnt, G_C1);
    pulse_end(1); pulse_done();
    eq("R11 cpu back", gnt, G_CPU);
    dreq = 0;

    // random configs and traffic
    for (int c = 0; c < 40; c++) begin
      en    = 2'($urandom_range(0, 3)) | 2'(c % 2 + 1);
      burst = 2'($urandom_range(0, 3));
      level = 2'($urandom_range(0, 3));
      pol   = 2'($urandom_range(0, 3));
      unit  = 4'($urandom_range(0, 15));
      dreq  = ~pol;
      do_reset(); tick(1);
      for (int k = 0; k < 2; k++)
        eq("R3 rand err", int'(err[k]),
           int'(en[k] && !legal_f(level[k], burst[k], unit[2*k +: 2])));
      g_prev = gnt; d_prev = 0;
      for (int t = 0; t < 300; t++) begin
        eq("R2 onehot", $countones(gnt), 1);
        if (g_prev != G_CPU && !d_prev)
          eq("R6 hold", gnt, g_prev);
        for (int k = 0; k < 2; k++) begin
          if (!en[k] || !legal_f(level[k], burst[k], unit[2*k +: 2]))
            eq("R3 R12 blocked", int'(gnt[k+1]), 0);
        end
        if (g_prev == G_C0 && d_prev && !burst[0])
          eq("R10 cs gap", int'(gnt[1]), 0);
        g_prev = gnt;
        if ($urandom_range(0, 7) == 0) dreq[$urandom_range(0, 1)] ^= 1'b1;
        endp = ($urandom_range(0, 31) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
        done = (gnt != G_CPU) && ($urandom_range(0, 2) == 0);
        d_prev = done;
        tick(1);
      end
      done = 0; endp = 0;
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule